// File: doc/BRIEF.md
# Burst Pseudo-Static Memory Write Controller

This block sits on the host side of a burst-capable pseudo-static memory and turns one request into a fixed four-beat synchronous write. A request carries a start address, four data words and two byte enables per word. When the controller accepts it, the controller drives an address phase and counts a fixed write latency. It then places the four words on the data bus on consecutive clocks, with per-beat upper and lower byte masks. Every memory-side output is a decode of registered state, timed to the same free-running clock that the memory receives.

The controller can chain bursts. If the next request is waiting when the current burst finishes, chip select stays low and only a new address strobe and address go out. A guard counts how long chip select has been low without a break. It refuses a chained request whose burst would run past the memory's 2.5 µs ceiling. It converts that ceiling into clock cycles from a clock-frequency parameter at elaboration. When it refuses, chip select rises for at least one cycle before the next burst.

Top module: `psram_burst_wr`

## Requirements
- R1: While reset is asserted, and after reset, the outputs are idle: `mem_cs_n`, `mem_adv_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_bytemask_n` is all ones, `mem_dq_oe` is 0, `mem_addr` and `mem_dq` are 0, and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. The following cycle is the address phase: `mem_cs_n`=0, `mem_adv_n`=0, `mem_we_n`=0 and `mem_addr` equal to the request address. `mem_adv_n` and `mem_we_n` are low for exactly that one cycle of each burst. `mem_addr` is 0 in every other cycle.
- R3: Counting the address phase as cycle 0, word i (i = 0..3, taken from `req_data[i*16 +: 16]`) is on `mem_dq`, with `mem_dq_oe`=1, in cycle LAT+i. LAT defaults to 5. In cycles 1 to LAT-1, chip select is low and the address strobe, write enable and data enable are all inactive.
- R4: During beat i, `mem_bytemask_n[0]` (lower byte) is the inverse of `req_be[2*i]` and `mem_bytemask_n[1]` (upper byte) is the inverse of `req_be[2*i+1]`. A beat whose two enables are both 0 has both masks at 1, so that word is not written. Outside the beats, both masks are 1.
- R5: `mem_dq_oe` is 1 only during the four beats, and only while `mem_cs_n` is 0. `mem_dq` is 0 whenever `mem_dq_oe` is 0. `mem_oe_n` is 1 at all times.
- R6: `req_ready` is 0 from the cycle after an acceptance until the last beat of that burst, so no burst starts before the previous one has finished.
- R7: If a request is valid during the last beat and the guard allows it, the next cycle is its address phase and `mem_cs_n` stays 0 across the boundary.
- R8: Chip select never stays low for more than MAX_CYC = CLK_MHZ*2500/1000 consecutive cycles (312 at 125 MHz). In the last beat, `req_ready` is 1 only if the low run so far, this cycle included, plus LAT+4 is no more than MAX_CYC.
- R9: If no request is accepted in the last beat, `mem_cs_n` returns to 1 in the next cycle and `req_ready` is 1 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, free-running |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | AW (22) | Burst start address |
| req_data | input | 4*DW (64) | Four words, word i in bits i*DW upward |
| req_be | input | 4*DW/8 (8) | Byte enables, 1 = write; bit 2i lower, 2i+1 upper byte of word i |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, held inactive |
| mem_addr | output | AW (22) | Memory address bus |
| mem_bytemask_n | output | DW/8 (2) | Byte masks, active low; bit 0 lower, bit 1 upper |
| mem_dq | output | DW (16) | Write data |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
If the latency or beat counter slips, the bad state shows in the first data cycle: a word appears one cycle early or late, or is repeated, and its byte masks are shifted the same way. A window counter that is wrong becomes visible only at the end of a long chain. There, chip select either stays low past 312 cycles or rises after the wrong burst, so the bench runs a chain longer than the ceiling allows and checks the longest low run exactly. A ready flag that is wrong shows at once as an extra or a lost address strobe, because every memory pin and `req_ready` are compared with a queue-based model on every clock.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_BEAT = 2'd3
  } wr_state_e;
endpackage

// File: rtl/psram_wr_seq.sv
module psram_wr_seq
  import psram_wr_pkg::*;
#(
  parameter int AW  = 22,
  parameter int DW  = 16,
  parameter int NB  = 2,
  parameter int BL  = 4,
  parameter int LAT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_addr,
  input  logic [BL*DW-1:0]    req_data,
  input  logic [BL*NB-1:0]    req_be,
  input  logic                chain_ok,
  output logic                req_ready,
  output wr_state_e           st_o,
  output logic [((BL > 1) ? $clog2(BL) : 1)-1:0] beat_o,
  output logic                last_o,
  output logic [AW-1:0]       cap_addr,
  output logic [BL*DW-1:0]    cap_data,
  output logic [BL*NB-1:0]    cap_be
);
  localparam int BW = (BL > 1) ? $clog2(BL) : 1;
  localparam int LW = $clog2(LAT);

  wr_state_e       st_q, st_d;
  logic [LW-1:0]   wcnt_q, wcnt_d;
  logic [BW-1:0]   beat_q, beat_d;
  logic            last_beat;
  logic            take;

  assign last_beat = (st_q == ST_BEAT) && (beat_q == BW'(BL - 1));
  assign req_ready = (st_q == ST_IDLE) || (last_beat && chain_ok);
  assign take      = req_valid && req_ready;

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    beat_d = beat_q;
    unique case (st_q)
      ST_IDLE: if (take) st_d = ST_ADDR;
      ST_ADDR: begin
        st_d   = ST_WAIT;
        wcnt_d = LW'(1);
      end
      ST_WAIT: begin
        if (wcnt_q == LW'(LAT - 1)) begin
          st_d   = ST_BEAT;
          beat_d = '0;
        end else begin
          wcnt_d = wcnt_q + LW'(1);
        end
      end
      ST_BEAT: begin
        if (last_beat) st_d = take ? ST_ADDR : ST_IDLE;
        else           beat_d = beat_q + BW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      beat_q <= beat_d;
    end
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk) begin
    if (take) begin
      cap_addr <= req_addr;
      cap_data <= req_data;
      cap_be   <= req_be;
    end
  end

  assign st_o   = st_q;
  assign beat_o = beat_q;
  assign last_o = last_beat;

  // R2: the address phase lasts a single cycle
  p_addr_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR) |=> (st_q == ST_WAIT));
  // R6: acceptance always leads to an address phase
  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (st_q == ST_ADDR));
  // R3: beats advance one word per clock
  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BEAT && !last_beat) |=> (st_q == ST_BEAT && beat_q == $past(beat_q) + BW'(1)));
  // R7: a permitted chained request skips idle
  p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && req_valid && chain_ok) |=> (st_q == ST_ADDR));
  // R9: without a request the controller releases the memory
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !req_valid) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/psram_wr_guard.sv
module psram_wr_guard #(
  parameter int MAX_CYC   = 312,
  parameter int BURST_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic chain_ok
);
  localparam int WW = $clog2(MAX_CYC + 1);

  logic [WW-1:0] win_q, win_d;

  always_comb begin
    if (!active)                      win_d = '0;
    else if (win_q == WW'(MAX_CYC))   win_d = win_q;
    else                              win_d = win_q + WW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  // low run including this cycle, plus one more burst, must fit the ceiling
  assign chain_ok = (32'(win_q) + 32'd1 + 32'(BURST_CYC)) <= 32'(MAX_CYC);

  // R8: chip-select low run stays within the ceiling
  p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (32'(win_q) < 32'(MAX_CYC)));
  // R8: the window restarts after every release
  p_window_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (win_q == '0));
endmodule

// File: rtl/psram_wr_beat.sv
module psram_wr_beat #(
  parameter int DW = 16,
  parameter int NB = 2,
  parameter int BL = 4
) (
  input  logic                beat_en,
  input  logic [((BL > 1) ? $clog2(BL) : 1)-1:0] beat_idx,
  input  logic [BL*DW-1:0]    cap_data,
  input  logic [BL*NB-1:0]    cap_be,
  output logic [DW-1:0]       dq,
  output logic                dq_oe,
  output logic [NB-1:0]       mask_n
);
  logic [DW-1:0] word;
  logic [NB-1:0] be_sel;

  assign word   = cap_data[beat_idx*DW +: DW];
  assign be_sel = cap_be[beat_idx*NB +: NB];
  assign dq     = beat_en ? word : '0;
  assign dq_oe  = beat_en;

  for (genvar g = 0; g < NB; g++) begin : g_mask
    assign mask_n[g] = !(beat_en && be_sel[g]);
  end
endmodule

// File: rtl/psram_burst_wr.sv
module psram_burst_wr
  import psram_wr_pkg::*;
#(
  parameter int CLK_MHZ = 125,
  parameter int AW      = 22,
  parameter int DW      = 16,
  parameter int BL      = 4,
  parameter int LAT     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [AW-1:0]          req_addr,
  input  logic [BL*DW-1:0]       req_data,
  input  logic [BL*(DW/8)-1:0]   req_be,
  output logic                   mem_cs_n,
  output logic                   mem_adv_n,
  output logic                   mem_we_n,
  output logic                   mem_oe_n,
  output logic [AW-1:0]          mem_addr,
  output logic [(DW/8)-1:0]      mem_bytemask_n,
  output logic [DW-1:0]          mem_dq,
  output logic                   mem_dq_oe
);
  localparam int NB        = DW / 8;
  localparam int BW        = (BL > 1) ? $clog2(BL) : 1;
  localparam int MAX_CYC   = (CLK_MHZ * 2500) / 1000;
  localparam int BURST_CYC = LAT + BL;

  logic [1:0]       rs_q;
  logic             rst_int_n;
  wr_state_e        st;
  logic [BW-1:0]    beat;
  logic             last;
  logic             chain_ok;
  logic [AW-1:0]    cap_addr;
  logic [BL*DW-1:0] cap_data;
  logic [BL*NB-1:0] cap_be;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  psram_wr_seq #(.AW(AW), .DW(DW), .NB(NB), .BL(BL), .LAT(LAT)) i_seq (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_be(req_be), .chain_ok(chain_ok), .req_ready(req_ready),
    .st_o(st), .beat_o(beat), .last_o(last),
    .cap_addr(cap_addr), .cap_data(cap_data), .cap_be(cap_be)
  );

  psram_wr_guard #(.MAX_CYC(MAX_CYC), .BURST_CYC(BURST_CYC)) i_guard (
    .clk(clk), .rst_n(rst_int_n), .active(st != ST_IDLE), .chain_ok(chain_ok)
  );

  psram_wr_beat #(.DW(DW), .NB(NB), .BL(BL)) i_beat (
    .beat_en(st == ST_BEAT), .beat_idx(beat), .cap_data(cap_data), .cap_be(cap_be),
    .dq(mem_dq), .dq_oe(mem_dq_oe), .mask_n(mem_bytemask_n)
  );

  assign mem_cs_n  = (st == ST_IDLE);
  assign mem_adv_n = (st != ST_ADDR);
  assign mem_we_n  = (st != ST_ADDR);
  assign mem_oe_n  = 1'b1;
  assign mem_addr  = (st == ST_ADDR) ? cap_addr : '0;

  // R5: data drive only inside a selected burst
  p_bus_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_dq_oe |-> !mem_cs_n);
  // R4: masks closed whenever no beat is on the bus
  p_mask_idle_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_dq_oe |-> (&mem_bytemask_n));
  // R3: the last beat is followed by a new strobe or by release
  p_after_last_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    last |=> (!mem_adv_n || mem_cs_n));
endmodule

// File: tb/test_psram_burst_wr.sv
`timescale 1ns/1ps
module test_psram_burst_wr;
  localparam int CLK_MHZ = 125, AW = 22, DW = 16, BL = 4, LAT = 5, NB = DW / 8;
  localparam int MAX_CYC = (CLK_MHZ * 2500) / 1000;
  localparam int BURST_CYC = LAT + BL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic [BL*DW-1:0] req_data;
  logic [BL*NB-1:0] req_be;
  logic mem_cs_n, mem_adv_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [NB-1:0] mem_bytemask_n;
  logic [DW-1:0] mem_dq;

  always #4 clk = ~clk;

  psram_burst_wr #(.CLK_MHZ(CLK_MHZ), .AW(AW), .DW(DW), .BL(BL), .LAT(LAT)) i_psram_burst_wr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_bytemask_n(mem_bytemask_n), .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
  );

  typedef struct {
    logic [AW-1:0]    addr;
    logic [BL*DW-1:0] data;
    logic [BL*NB-1:0] be;
    int               gap;
  } req_t;

  typedef struct {
    logic          cs_n, adv_n, we_n, dq_oe;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq;
    logic [NB-1:0] mask_n;
    bit            last;
  } exp_t;

  req_t reqs[$];
  exp_t expq[$];
  int n_cmp = 0, n_bad = 0, run = 0, max_run = 0, gap_left = 0;
  bit model_on = 1'b0;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic exp_t idle_rec();
    exp_t e;
    e.cs_n = 1'b1; e.adv_n = 1'b1; e.we_n = 1'b1; e.dq_oe = 1'b0;
    e.addr = '0; e.dq = '0; e.mask_n = '1; e.last = 1'b0;
    return e;
  endfunction

  task automatic push_burst(req_t r);
    for (int k = 0; k < BURST_CYC; k++) begin
      exp_t e = idle_rec();
      e.cs_n = 1'b0;
      if (k == 0) begin
        e.adv_n = 1'b0; e.we_n = 1'b0; e.addr = r.addr;
      end else if (k >= LAT) begin
        e.dq_oe = 1'b1;
        e.dq = r.data[(k - LAT) * DW +: DW];
        for (int b = 0; b < NB; b++) e.mask_n[b] = ~r.be[(k - LAT) * NB + b];
        e.last = (k == BURST_CYC - 1);
      end
      expq.push_back(e);
    end
  endtask

  function automatic req_t mk(int gap, logic [BL*NB-1:0] be);
    req_t r;
    r.addr = AW'($urandom);
    r.data = {$urandom, $urandom};
    r.be = be;
    r.gap = gap;
    return r;
  endfunction

  always @(negedge clk) begin
    exp_t e;
    bit er;
    if (model_on) begin
      if (expq.size() == 0) begin
        e = idle_rec(); er = 1'b1;
      end else begin
        e = expq.pop_front();
        er = e.last && (run + 1 + BURST_CYC <= MAX_CYC);  // R8 gate
      end
      chk("R6", "req_ready", req_ready, er);
      chk("R7 R9", "mem_cs_n", mem_cs_n, e.cs_n);
      chk("R2", "mem_adv_n", mem_adv_n, e.adv_n);
      chk("R2", "mem_we_n", mem_we_n, e.we_n);
      chk("R2", "mem_addr", mem_addr, e.addr);
      chk("R3", "mem_dq_oe", mem_dq_oe, e.dq_oe);
      chk("R3", "mem_dq", mem_dq, e.dq);
      chk("R4", "mem_bytemask_n", mem_bytemask_n, e.mask_n);
      chk("R5", "mem_oe_n", mem_oe_n, 1);
      run = e.cs_n ? 0 : run + 1;
      if (run > max_run) max_run = run;
      if (reqs.size() > 0 && gap_left == 0) begin
        req_valid = 1'b1;
        req_addr = reqs[0].addr;
        req_data = reqs[0].data;
        req_be = reqs[0].be;
        if (er) begin
          push_burst(reqs[0]);
          void'(reqs.pop_front());
          if (reqs.size() > 0) gap_left = reqs[0].gap;
        end
      end else begin
        req_valid = 1'b0;
        if (gap_left > 0) gap_left--;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_addr = '0; req_data = '0; req_be = '0;
    repeat (3) @(negedge clk);
    // R1: idle outputs under reset
    chk("R1", "mem_cs_n", mem_cs_n, 1);
    chk("R1", "mem_adv_n", mem_adv_n, 1);
    chk("R1", "mem_we_n", mem_we_n, 1);
    chk("R1", "mem_oe_n", mem_oe_n, 1);
    chk("R1", "mem_dq_oe", mem_dq_oe, 0);
    chk("R1", "mem_bytemask_n", mem_bytemask_n, 2'b11);
    chk("R1", "mem_addr", mem_addr, 0);
    chk("R1", "req_ready", req_ready, 1);
    // single burst, all bytes written
    reqs.push_back(mk(5, 8'hFF));
    // R4: beat 2 fully masked, partial masks elsewhere
    reqs.push_back(mk(6, 8'b10_00_01_11));
    // R7: three chained bursts
    reqs.push_back(mk(4, 8'hFF));
    reqs.push_back(mk(0, 8'b01_10_11_00));
    reqs.push_back(mk(0, 8'hA5));
    // R8: chain longer than the ceiling allows
    for (int i = 0; i < 40; i++) reqs.push_back(mk((i == 0) ? 3 : 0, 8'($urandom)));
    // R9: isolated burst after a pause
    reqs.push_back(mk(2, 8'h3C));
    gap_left = reqs[0].gap;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 model_on = 1'b1;
    wait (reqs.size() == 0 && expq.size() == 0);
    repeat (5) @(negedge clk);
    // R8: longest low run equals the largest whole number of bursts under the ceiling
    chk("R8", "longest cs_n low run", max_run, (MAX_CYC / BURST_CYC) * BURST_CYC);
    summary();
    $finish;
  end
endmodule